// File: doc/BRIEF.md
# Vector Averaging Add/Subtract Unit

This block is the element datapath for the averaging add and subtract group of a vector integer pipeline. Each cycle it may accept one element: a 32-bit instruction word, two operands, an element-width select, a fixed-point rounding mode and a mask bit. From the instruction word it decides whether the word is one of the four averaging operations it serves. If the word is one of them, it forms the sum or difference exactly, halves it, and applies a rounding increment.

The halving is exact. Operands are widened by one bit, using sign extension for the signed operations and zero extension for the unsigned ones, before the add or subtract. The carry of an unsigned add and the borrow of an unsigned subtract therefore land in the top bit of the halved result and are not lost. Register-file access, vector-length handling and the stepping through elements are left to the surrounding pipeline, which feeds one element at a time and supplies the old destination value for masked-off elements.

Top module: `vavg_unit`

## Requirements
- R1: Instruction bits [31:26] pick the operation. 001000 is unsigned averaging add, 001001 is signed averaging add, 001010 is unsigned averaging subtract and 001011 is signed averaging subtract.
- R2: A word is accepted only when bits [6:0] are 1010111 and bits [14:12] are 010 (vector-vector) or 110 (vector-scalar). Both forms take the second operand from the low element-width bits of `opnd_b` and give identical results.
- R3: Any other opcode, any other funct6, or bits [14:12] equal to 011 (an immediate form, which this group does not have) makes `illegal` high one cycle after `in_valid`. In that case `res_valid` stays low and `result` keeps its previous value.
- R4: The result is the exact A+B or A−B, computed one bit wider than the element, shifted right by one, plus a 0/1 rounding increment, and truncated to the element width. For unsigned add, the carry becomes the top result bit.
- R5: For unsigned subtract, a borrow sets the top bit of the halved result. The difference is treated as a two's-complement value one bit wider than the element.
- R6: `rnd_mode` selects the increment from the dropped bit d and the kept LSB k. 00 adds d. 01 adds d only when k is 1. 10 adds nothing. 11 adds d only when k is 0, so the result LSB becomes 1.
- R7: `elem_sel` 0, 1, 2, 3 selects 8, 16, 32 or 64-bit elements. Operand bits above the element width are ignored, and result bits above it are zero.
- R8: An element is active when instruction bit 25 is 1 or `mask_bit` is 1. A legal but inactive element returns `prev_dst` unchanged, with `res_valid` high.
- R9: `res_valid` and `illegal` are registered and rise exactly one clock after an `in_valid` cycle. In a cycle without `in_valid`, both are low on the next clock and `result` holds.
- R10: Synchronous active-low reset clears `result`, `res_valid` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An element is presented this cycle |
| instr | input | 32 | Instruction word |
| opnd_a | input | 64 | First operand (vector element) |
| opnd_b | input | 64 | Second operand (vector element or scalar) |
| elem_sel | input | 2 | Element width: 0=8, 1=16, 2=32, 3=64 bits |
| rnd_mode | input | 2 | Fixed-point rounding mode |
| mask_bit | input | 1 | Mask bit for this element |
| prev_dst | input | 64 | Old destination value, returned for inactive elements |
| result | output | 64 | Registered result |
| res_valid | output | 1 | Result produced for a legal instruction |
| illegal | output | 1 | Instruction word rejected |

## Verification
The hardest cases to reach are those where the carry or borrow out of the element reaches the top result bit and the rounding increment then wraps the kept value. Random operands almost never produce these. The stimulus therefore sweeps fixed extreme pairs through every combination of operation, width and rounding mode: both maxima, signed minimum against signed maximum, zero minus maximum, and both signed minima. Garbage is placed above the element width so that truncation is tested at the same time. Hand-computed literal results back up the model on a few of these points.

// File: rtl/vavg_pkg.sv
// Shared types for the averaging add/subtract unit.
// Assumes: the caller decodes nothing itself; the unit sees raw instruction words.
package vavg_pkg;

    localparam logic [6:0] OPC_VEC  = 7'b1010111;
    localparam logic [3:0] FN6_HIGH = 4'b0010;
    localparam logic [2:0] CAT_VV   = 3'b010;
    localparam logic [2:0] CAT_VX   = 3'b110;

    // Operation kind, taken straight from the low two funct6 bits
    typedef struct packed {
        logic sub;   // 1: subtract, 0: add
        logic sgn;   // 1: signed operands
    } avg_op_t;

    typedef enum logic [1:0] {
        RM_NEAR_UP   = 2'd0,
        RM_NEAR_EVEN = 2'd1,
        RM_DOWN      = 2'd2,
        RM_ODD       = 2'd3
    } rmode_e;

    typedef struct packed {
        logic    legal;
        logic    active;
        avg_op_t op;
    } avg_dec_t;

endpackage

// File: rtl/vavg_decode.sv
// Instruction decoder: checks opcode, category and function code, and
// derives operation kind and element activity.
// Assumes: only the four averaging function codes belong to this unit.
module vavg_decode
    import vavg_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        mask_bit,
    output avg_dec_t    dec
);

    logic [5:0] fn6;
    logic [2:0] cat;
    logic [6:0] opc;
    logic       unused_fields;

    assign fn6 = instr[31:26];
    assign cat = instr[14:12];
    assign opc = instr[6:0];
    assign unused_fields = ^{instr[24:15], instr[11:7]};

    // Purpose: legality, activity and op-kind decode
    always_comb begin
        dec.legal  = (opc == OPC_VEC) && (fn6[5:2] == FN6_HIGH) &&
                     ((cat == CAT_VV) || (cat == CAT_VX));
        dec.active = instr[25] | mask_bit;
        dec.op.sub = fn6[1];
        dec.op.sgn = fn6[0];
    end

endmodule

// File: rtl/vavg_round.sv
// Fixed-point rounding for a single dropped bit.
// Assumes: the kept value is already shifted; the increment wraps at W bits.
module vavg_round
    import vavg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] kept,
    input  logic         dropped,
    input  rmode_e       rm,
    output logic [W-1:0] rounded
);

    logic inc;

    // Purpose: choose the 0/1 increment from mode, dropped bit and kept LSB
    always_comb begin
        unique case (rm)
            RM_NEAR_UP:   inc = dropped;
            RM_NEAR_EVEN: inc = dropped & kept[0];
            RM_DOWN:      inc = 1'b0;
            RM_ODD:       inc = dropped & ~kept[0];
            default:      inc = 1'b0;
        endcase
        rounded = kept + {{(W-1){1'b0}}, inc};
    end

endmodule

// File: rtl/vavg_lane.sv
// One element-width lane: exact add/subtract one bit wide, halve, round.
// Assumes: operands are exactly W bits; signedness comes from op.sgn.
module vavg_lane
    import vavg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  avg_op_t      op,
    input  rmode_e       rm,
    output logic [W-1:0] res
);

    logic [W:0] ext_a;
    logic [W:0] ext_b;
    logic [W:0] raw;

    // Purpose: widen operands and form the exact W+1-bit sum or difference
    always_comb begin
        ext_a = {op.sgn & a[W-1], a};
        ext_b = {op.sgn & b[W-1], b};
        raw   = op.sub ? (ext_a - ext_b) : (ext_a + ext_b);
    end

    vavg_round #(.W(W)) u_round (
        .kept    (raw[W:1]),
        .dropped (raw[0]),
        .rm      (rm),
        .rounded (res)
    );

endmodule

// File: rtl/vavg_unit.sv
// Averaging add/subtract unit: decodes the word, computes every width in
// parallel lanes, selects one, and registers result and flags.
// Assumes: one element per cycle; prev_dst supplied by the register file path.
module vavg_unit
    import vavg_pkg::*;
#(
    parameter  int MAX_EW   = 64,
    parameter  int N_WIDTHS = 4,
    localparam int SELW     = $clog2(N_WIDTHS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [MAX_EW-1:0] opnd_a,
    input  logic [MAX_EW-1:0] opnd_b,
    input  logic [SELW-1:0]   elem_sel,
    input  logic [1:0]        rnd_mode,
    input  logic              mask_bit,
    input  logic [MAX_EW-1:0] prev_dst,
    output logic [MAX_EW-1:0] result,
    output logic              res_valid,
    output logic              illegal
);

    localparam int MIN_EW = MAX_EW >> (N_WIDTHS - 1);

    avg_dec_t          dec;
    rmode_e            rm;
    logic [MAX_EW-1:0] lane_res [N_WIDTHS];
    logic [MAX_EW-1:0] pick;

    assign rm = rmode_e'(rnd_mode);

    vavg_decode u_dec (
        .instr    (instr),
        .mask_bit (mask_bit),
        .dec      (dec)
    );

    for (genvar gi = 0; gi < N_WIDTHS; gi++) begin : g_lane
        localparam int LW = MIN_EW << gi;
        logic [LW-1:0] lr;

        vavg_lane #(.W(LW)) u_lane (
            .a   (opnd_a[LW-1:0]),
            .b   (opnd_b[LW-1:0]),
            .op  (dec.op),
            .rm  (rm),
            .res (lr)
        );

        if (LW < MAX_EW) begin : g_pad
            assign lane_res[gi] = {{(MAX_EW-LW){1'b0}}, lr};
        end else begin : g_full
            assign lane_res[gi] = lr;
        end
    end

    // Purpose: pick the lane for the selected width, or pass-through if inactive
    always_comb begin
        pick = dec.active ? lane_res[elem_sel] : prev_dst;
    end

    // Purpose: output registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            res_valid <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            res_valid <= in_valid & dec.legal;
            illegal   <= in_valid & ~dec.legal;
            if (in_valid && dec.legal) begin
                result <= pick;
            end
        end
    end

endmodule

// File: rtl/vavg_unit_chk.sv
// Property checker for vavg_unit, attached by bind below.
// Assumes: port names identical to the unit's.
module vavg_unit_chk #(
    parameter  int MAX_EW   = 64,
    parameter  int N_WIDTHS = 4,
    localparam int SELW     = $clog2(N_WIDTHS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic [SELW-1:0]   elem_sel,
    input logic              mask_bit,
    input logic [MAX_EW-1:0] prev_dst,
    input logic [MAX_EW-1:0] result,
    input logic              res_valid,
    input logic              illegal
);

    localparam int MIN_EW = MAX_EW >> (N_WIDTHS - 1);

    logic unused_chk_bits;
    logic word_ok;

    assign unused_chk_bits = ^{instr[24:15], instr[11:7]};
    assign word_ok = (instr[6:0] == 7'b1010111) && (instr[31:28] == 4'b0010) &&
                     ((instr[14:12] == 3'b010) || (instr[14:12] == 3'b110));

    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !illegal && result == '0));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !illegal));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && illegal));

    assert_bad_opcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[6:0] != 7'b1010111) |=> (illegal && !res_valid));

    assert_no_imm_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[14:12] == 3'b011) |=> illegal);

    assert_masked_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && word_ok && !instr[25] && !mask_bit)
        |=> (res_valid && result == $past(prev_dst)));

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && word_ok && elem_sel == '0 && (instr[25] || mask_bit))
        |=> ((result >> MIN_EW) == '0));

endmodule

bind vavg_unit vavg_unit_chk #(.MAX_EW(MAX_EW), .N_WIDTHS(N_WIDTHS)) i_chk (.*);

// File: tb/test_vavg_unit.sv
`timescale 1ns/1ps
module test_vavg_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [1:0]  elem_sel = '0;
    logic [1:0]  rnd_mode = '0;
    logic        mask_bit = 1'b0;
    logic [63:0] prev_dst = '0;
    logic [63:0] result;
    logic        res_valid;
    logic        illegal;

    int          total = 0;
    int          bad = 0;
    logic [63:0] model_res = '0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    vavg_unit i_vavg_unit (.*);

    function automatic logic [63:0] wmask(input logic [1:0] ew);
        int w;
        w = 8 << ew;
        return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    // Behavioural golden model: 67-bit integer arithmetic
    function automatic logic [63:0] golden(input logic [1:0] op, input logic [1:0] ew,
                                           input logic [1:0] rm,
                                           input logic [63:0] a, input logic [63:0] b);
        int          w;
        logic [66:0] xa, xb, d, q;
        logic        drop, inc;
        w  = 8 << ew;
        xa = {3'b0, a & wmask(ew)};
        xb = {3'b0, b & wmask(ew)};
        if (op[0] && a[w-1]) xa = xa - (67'd1 << w);
        if (op[0] && b[w-1]) xb = xb - (67'd1 << w);
        d    = op[1] ? xa - xb : xa + xb;
        drop = d[0];
        q    = {d[66], d[66:1]};
        case (rm)
            2'd0:    inc = drop;
            2'd1:    inc = drop & q[0];
            2'd2:    inc = 1'b0;
            default: inc = drop & ~q[0];
        endcase
        q = q + {66'd0, inc};
        return q[63:0] & wmask(ew);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one element at the falling edge, compare one clock later
    task automatic issue(input string tag, input logic [5:0] fn6, input logic [2:0] cat,
                         input logic [6:0] opc, input logic [1:0] ew, input logic [1:0] rm,
                         input logic [63:0] a, input logic [63:0] b, input logic vm,
                         input logic mb, input logic [63:0] pd);
        logic legal, act;
        @(negedge clk);
        instr    = {fn6, vm, 5'd4, 5'd9, cat, 5'd2, opc};
        opnd_a   = a;
        opnd_b   = b;
        elem_sel = ew;
        rnd_mode = rm;
        mask_bit = mb;
        prev_dst = pd;
        in_valid = 1'b1;
        legal = (opc == 7'b1010111) && (fn6[5:2] == 4'b0010) &&
                (cat == 3'b010 || cat == 3'b110);
        act = vm | mb;
        if (legal) model_res = act ? golden(fn6[1:0], ew, rm, a, b) : pd;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check(tag, "res_valid", {63'd0, res_valid}, {63'd0, legal});
        check(tag, "illegal", {63'd0, illegal}, {63'd0, ~legal});
        check(tag, "result", result, model_res);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        opnd_a   = {$urandom, $urandom};
        instr    = $urandom;
        @(posedge clk);
        #1;
        check(tag, "idle res_valid", {63'd0, res_valid}, 64'd0);
        check(tag, "idle illegal", {63'd0, illegal}, 64'd0);
        check(tag, "idle result", result, model_res);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] pa [8];
        logic [63:0] pb [8];
        logic [63:0] m, smin, smax, junk;

        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R10", "reset result", result, 64'd0);
        check("R10", "reset flags", {62'd0, res_valid, illegal}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 R5 R6: literal spot values (8-bit)
        issue("R4", 6'b001000, 3'b010, 7'b1010111, 2'd0, 2'd0, 64'hFF, 64'hFF, 1, 0, 0);
        check("R4", "addu ff+ff", result, 64'hFF);
        issue("R5", 6'b001010, 3'b010, 7'b1010111, 2'd0, 2'd0, 64'h00, 64'hFF, 1, 0, 0);
        check("R5", "subu 0-ff rnu", result, 64'h81);
        issue("R1", 6'b001001, 3'b010, 7'b1010111, 2'd0, 2'd2, 64'h80, 64'h80, 1, 0, 0);
        check("R1", "adds 80+80", result, 64'h80);
        issue("R6", 6'b001000, 3'b010, 7'b1010111, 2'd0, 2'd1, 64'h1, 64'h2, 1, 0, 0);
        check("R6", "rne 1+2", result, 64'h2);
        issue("R6", 6'b001000, 3'b010, 7'b1010111, 2'd0, 2'd1, 64'h1, 64'h0, 1, 0, 0);
        check("R6", "rne 1+0", result, 64'h0);
        issue("R6", 6'b001000, 3'b010, 7'b1010111, 2'd0, 2'd3, 64'h1, 64'h2, 1, 0, 0);
        check("R6", "rod 1+2", result, 64'h1);
        issue("R6", 6'b001000, 3'b010, 7'b1010111, 2'd0, 2'd3, 64'h1, 64'h0, 1, 0, 0);
        check("R6", "rod 1+0", result, 64'h1);
        issue("R4", 6'b001000, 3'b110, 7'b1010111, 2'd3, 2'd2, '1, '1, 1, 0, 0);
        check("R4", "64-bit addu carry kept", result, 64'hFFFF_FFFF_FFFF_FFFF);
        issue("R7", 6'b001000, 3'b010, 7'b1010111, 2'd1, 2'd0, 64'hABCD_0000_0000_0003,
              64'h1234_0000_0001_0001, 1, 0, 0);
        check("R7", "16-bit upper ignored", result, 64'h2);

        // R1 R2 R4 R5 R6 R7: extreme pairs across ops, widths, modes, both forms
        for (int ew = 0; ew < 4; ew++) begin
            m    = wmask(ew[1:0]);
            smin = (m >> 1) + 64'd1;
            smax = m >> 1;
            junk = ({$urandom, $urandom}) & ~m;
            pa[0] = m;    pb[0] = m;
            pa[1] = smin; pb[1] = smax;
            pa[2] = 0;    pb[2] = m;
            pa[3] = smin; pb[3] = smin;
            pa[4] = smax; pb[4] = smax;
            pa[5] = 0;    pb[5] = smax;
            pa[6] = 1;    pb[6] = 0;
            pa[7] = {$urandom, $urandom}; pb[7] = {$urandom, $urandom};
            for (int op = 0; op < 4; op++) begin
                for (int rm = 0; rm < 4; rm++) begin
                    for (int p = 0; p < 8; p++) begin
                        issue("R4", {4'b0010, op[1:0]}, (p[0] ? 3'b110 : 3'b010),
                              7'b1010111, ew[1:0], rm[1:0], pa[p] | junk, pb[p] | junk,
                              1, 0, 0);
                    end
                end
            end
        end

        // R2: random vector-scalar traffic
        for (int i = 0; i < 300; i++) begin
            issue("R2", {4'b0010, 2'($urandom)}, 3'b110, 7'b1010111, 2'($urandom),
                  2'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, 1, 0, 0);
        end

        // R8: masked-off elements pass prev_dst; mask bit alone re-activates
        issue("R8", 6'b001011, 3'b010, 7'b1010111, 2'd2, 2'd0, 64'h5, 64'h3, 0, 0,
              64'hDEAD_BEEF_0123_4567);
        check("R8", "inactive pass-through", result, 64'hDEAD_BEEF_0123_4567);
        issue("R8", 6'b001011, 3'b010, 7'b1010111, 2'd2, 2'd0, 64'h5, 64'h3, 0, 1,
              64'hDEAD_BEEF_0123_4567);
        check("R8", "mask bit active", result, 64'h1);

        // R3: immediate form, foreign funct6, wrong opcode; result must hold
        issue("R3", 6'b001001, 3'b011, 7'b1010111, 2'd0, 2'd0, 64'h7, 64'h9, 1, 0, 0);
        check("R3", "imm form result held", result, 64'h1);
        issue("R3", 6'b100100, 3'b010, 7'b1010111, 2'd0, 2'd0, 64'h7, 64'h9, 1, 0, 0);
        issue("R3", 6'b001000, 3'b010, 7'b0110011, 2'd0, 2'd0, 64'h7, 64'h9, 1, 0, 0);
        issue("R3", 6'b001000, 3'b000, 7'b1010111, 2'd0, 2'd0, 64'h7, 64'h9, 1, 0, 0);

        // R9: idle cycles hold result and drop flags
        issue("R9", 6'b001000, 3'b010, 7'b1010111, 2'd0, 2'd0, 64'h10, 64'h20, 1, 0, 0);
        idle("R9");
        idle("R9");

        // R10: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        model_res = '0;
        check("R10", "mid-run reset result", result, 64'd0);
        check("R10", "mid-run reset flags", {62'd0, res_valid, illegal}, 64'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule